// File: doc/BRIEF.md
# Reset Vector Start-Up Sequencer

This block governs how a small processor comes out of reset. An active-low reset input holds the core parked: no memory reads, no program-counter load, and run-enable low. Once reset is seen high on a clock edge, the sequencer counts a fixed seven-cycle start sequence. The first five cycles are idle, and the read strobe stays low in them. The last two cycles read a two-byte start address from a fixed vector location near the top of the 16-bit space, with the lower-addressed byte as the low half.

In the eighth cycle the sequencer drives a program-counter load with the assembled address and raises a one-cycle done pulse. From that cycle on, run-enable stays high and the core fetches normally. The block also holds the program counter itself. While running, the counter steps on request from the core and wraps from the top address back to zero. No other processor state is touched by the sequence.

The memory port is synchronous: a byte read addressed in one cycle returns its data in the following cycle.

Top module: `reset_vector_sequencer`

## Requirements
- R1: While `rst_n` is sampled low, `run_en`, `mem_rd`, `pc_load` and `seq_done` are 0 at the next edge, and `pc` is 0x0000.
- R2: Counting the first cycle after the edge that samples `rst_n` high as cycle 1, cycles 1 to 5 have `mem_rd` = 0 and no `pc_load`.
- R3: Cycle 6 reads address 0xFFFC and cycle 7 reads address 0xFFFD, with `mem_rd` = 1 in both. The read strobe is never raised at any other address.
- R4: In cycle 8, `pc_load` is 1 and `pc_load_value` = {byte at 0xFFFD, byte at 0xFFFC}. Each byte is taken from `mem_rdata` one cycle after its address was presented.
- R5: `seq_done` is high in cycle 8 only, as a single-cycle pulse.
- R6: `run_en` is 0 in cycles 1 to 7, becomes 1 in cycle 8, and stays 1 until reset.
- R7: `pc` equals the loaded vector in cycle 9. A `pc_step` request before the core runs has no effect on `pc`.
- R8: While running, each cycle with `pc_step` = 1 adds one to `pc` modulo 2^16, so 0xFFFF steps to 0x0000.
- R9: Asserting `rst_n` low at any cycle of the sequence, including cycle 8, returns the block to the parked state. The next release runs the full seven-cycle count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| pc_step | input | 1 | Core request to advance the program counter |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| pc_load | output | 1 | Program-counter load strobe |
| pc_load_value | output | 16 | Address being loaded into the program counter |
| seq_done | output | 1 | One-cycle pulse marking the end of the start sequence |
| run_en | output | 1 | Enables normal fetch in the core |
| pc | output | 16 | Program counter |

## Verification
The start sequence is run with eighteen vector values: all zeros, all ones, and a single walking one across every bit position. Across these values, a swapped byte order, a byte taken in the wrong cycle, or a stuck bit in the assembled address each gives a different load value. The all-ones vector also makes the first step after start-up wrap to zero. Reset is then reasserted at each of the eight sequence cycles in turn. Each abort is followed by a complete fresh run, which shows whether the count restarts from one or resumes part-way.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_SEQ  = 2'd1,
        PH_LOAD = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   rd_en;
        logic   cap_en;
        logic   load;
        logic   run;
    } boot_ctrl_t;

    // Sequence cycle in which the first vector byte is read
    function automatic int first_read_cycle(input int start_cycles, input int vec_bytes);
        return start_cycles - vec_bytes + 1;
    endfunction

    function automatic int idx_width(input int vec_bytes);
        return (vec_bytes > 1) ? $clog2(vec_bytes) : 1;
    endfunction

endpackage

// File: rtl/boot_phase_ctrl.sv
module boot_phase_ctrl
    import boot_seq_pkg::*;
#(
    parameter int START_CYCLES = 7,
    parameter int VEC_BYTES    = 2,
    parameter int IDX_W        = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output boot_ctrl_t       ctrl,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] cap_idx
);
    localparam int CNT_W    = $clog2(START_CYCLES + 1);
    localparam int FIRST_RD = first_read_cycle(START_CYCLES, VEC_BYTES);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(START_CYCLES);
    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(FIRST_RD);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rd_off;
    logic [CNT_W-1:0] cap_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_HOLD: begin
                    phase_q <= PH_SEQ;
                    cnt_q   <= CNT_W'(1);
                end
                PH_SEQ: begin
                    if (cnt_q == LAST_C) begin
                        phase_q <= PH_LOAD;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_LOAD: phase_q <= PH_RUN;
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    always_comb begin
        rd_off       = cnt_q - FIRST_C;
        cap_off      = cnt_q - FIRST_C - CNT_W'(1);
        rd_idx       = IDX_W'(rd_off);
        cap_idx      = IDX_W'(cap_off);
        ctrl.phase   = phase_q;
        ctrl.rd_en   = (phase_q == PH_SEQ) && (cnt_q >= FIRST_C);
        ctrl.cap_en  = (phase_q == PH_SEQ) && (cnt_q > FIRST_C);
        ctrl.load    = (phase_q == PH_LOAD);
        ctrl.run     = (phase_q == PH_LOAD) || (phase_q == PH_RUN);
    end

    // R9
    restart_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD) |=> (phase_q == PH_SEQ && cnt_q == CNT_W'(1)));

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SEQ && cnt_q != LAST_C) |=> (phase_q == PH_SEQ && cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/boot_vector_latch.sv
module boot_vector_latch #(
    parameter int DATA_W    = 8,
    parameter int VEC_BYTES = 2,
    parameter int IDX_W     = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en,
    input  logic [IDX_W-1:0]            cap_idx,
    input  logic [DATA_W-1:0]           rdata,
    output logic [DATA_W*VEC_BYTES-1:0] vector
);
    localparam int HELD = VEC_BYTES - 1;

    // Lower bytes are held; the top byte is used straight from the read port
    generate
        for (genvar b = 0; b < HELD; b++) begin : g_byte
            logic [DATA_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q <= '0;
                else if (cap_en && cap_idx == IDX_W'(b))
                    byte_q <= rdata;
            end
            assign vector[b*DATA_W +: DATA_W] = byte_q;
        end
    endgenerate

    assign vector[HELD*DATA_W +: DATA_W] = rdata;

endmodule

// File: rtl/boot_pc_reg.sv
module boot_pc_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              run,
    input  logic              step,
    output logic [ADDR_W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (load)
            pc <= load_val;
        else if (run && step)
            pc <= pc + ADDR_W'(1);
    end

    // R7
    pc_load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pc == $past(load_val)));

    // R8
    pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && step && pc == '1) |=> (pc == '0));

    // R7
    pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(pc));

endmodule

// File: rtl/reset_vector_sequencer.sv
module reset_vector_sequencer
    import boot_seq_pkg::*;
#(
    parameter int              ADDR_W       = 16,
    parameter int              DATA_W       = 8,
    parameter int              START_CYCLES = 7,
    parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_step,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_load_value,
    output logic              seq_done,
    output logic              run_en,
    output logic [ADDR_W-1:0] pc
);
    localparam int VEC_BYTES = ADDR_W / DATA_W;
    localparam int IDX_W     = idx_width(VEC_BYTES);

    boot_ctrl_t       ctrl;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] cap_idx;

    boot_phase_ctrl #(
        .START_CYCLES(START_CYCLES),
        .VEC_BYTES   (VEC_BYTES),
        .IDX_W       (IDX_W)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl),
        .rd_idx (rd_idx),
        .cap_idx(cap_idx)
    );

    boot_vector_latch #(
        .DATA_W   (DATA_W),
        .VEC_BYTES(VEC_BYTES),
        .IDX_W    (IDX_W)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (ctrl.cap_en),
        .cap_idx(cap_idx),
        .rdata  (mem_rdata),
        .vector (pc_load_value)
    );

    boot_pc_reg #(
        .ADDR_W(ADDR_W)
    ) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctrl.load),
        .load_val(pc_load_value),
        .run     (ctrl.run),
        .step    (pc_step),
        .pc      (pc)
    );

    always_comb begin
        mem_rd   = ctrl.rd_en;
        mem_addr = ctrl.rd_en ? (VEC_ADDR + ADDR_W'(rd_idx)) : '0;
        pc_load  = ctrl.load;
        seq_done = ctrl.load;
        run_en   = ctrl.run;
    end

    // R1
    parked_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!run_en && !mem_rd && !pc_load && !seq_done));

    // R3
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr >= VEC_ADDR && mem_addr < VEC_ADDR + ADDR_W'(VEC_BYTES)));

    // R3
    low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> (mem_addr == VEC_ADDR));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R6
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> run_en);

    // R6
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> (seq_done && !mem_rd));

endmodule

// File: tb/test_reset_vector_sequencer.sv
`timescale 1ns/1ps
module test_reset_vector_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pc_step;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic        pc_load;
    logic [15:0] pc_load_value;
    logic        seq_done;
    logic        run_en;
    logic [15:0] pc;

    logic [15:0] vec;
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    reset_vector_sequencer i_reset_vector_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_step      (pc_step),
        .mem_addr     (mem_addr),
        .mem_rd       (mem_rd),
        .mem_rdata    (mem_rdata),
        .pc_load      (pc_load),
        .pc_load_value(pc_load_value),
        .seq_done     (seq_done),
        .run_en       (run_en),
        .pc           (pc)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        if (a == 16'hFFFC) return vec[7:0];
        if (a == 16'hFFFD) return vec[15:8];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Synchronous memory: data one cycle after the address
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_byte(mem_addr);
        else        mem_rdata <= 8'hEE;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_parked(input string req);
        chk(run_en == 1'b0, req, run_en, 0);
        chk(mem_rd == 1'b0, req, mem_rd, 0);
        chk(pc_load == 1'b0, req, pc_load, 0);
        chk(seq_done == 1'b0, req, seq_done, 0);
        chk(pc == 16'h0000, req, pc, 0);
    endtask

    // Called at a negedge with rst_n low; leaves the block running
    task automatic run_full(input logic [15:0] v);
        vec     = v;
        rst_n   = 1'b1;
        pc_step = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k <= 5) begin
                chk(mem_rd == 1'b0, "R2 dummy no read", mem_rd, 0);
                chk(pc_load == 1'b0, "R2 dummy no load", pc_load, 0);
            end
            if (k == 6 || k == 7) begin
                chk(mem_rd == 1'b1, "R3 vector read strobe", mem_rd, 1);
                chk(mem_addr == 16'hFFFC + 16'(k - 6), "R3 vector address", mem_addr, 16'hFFFC + 16'(k - 6));
            end
            if (k == 8) begin
                chk(pc_load == 1'b1, "R4 load strobe", pc_load, 1);
                chk(pc_load_value == v, "R4 load value", pc_load_value, v);
                chk(mem_rd == 1'b0, "R3 no read after vector", mem_rd, 0);
            end else begin
                chk(pc_load == 1'b0, "R4 load only in cycle 8", pc_load, 0);
            end
            chk(seq_done == (k == 8), "R5 done pulse", seq_done, (k == 8));
            chk(run_en == (k >= 8), "R6 run enable", run_en, (k >= 8));
            if (k <= 8) chk(pc == 16'h0000, "R7 step ignored before run", pc, 0);
            if (k == 9) chk(pc == v, "R7 pc holds vector", pc, v);
            if (k == 10) chk(pc == 16'(v + 16'd1), "R8 step wraps", pc, 16'(v + 16'd1));
            if (k == 11) begin
                chk(pc == 16'(v + 16'd2), "R8 second step", pc, 16'(v + 16'd2));
                pc_step = 1'b0;
            end
            if (k == 12) chk(pc == 16'(v + 16'd2), "R8 no step holds", pc, 16'(v + 16'd2));
        end
    endtask

    task automatic park();
        rst_n   = 1'b0;
        pc_step = 1'b1;
        @(negedge clk);
        chk_parked("R1 parked after reset");
    endtask

    initial begin
        rst_n     = 1'b0;
        pc_step   = 1'b1;
        vec       = 16'h0000;
        mem_rdata = 8'h00;
        repeat (3) @(negedge clk);
        chk_parked("R1 held in reset");

        // Vector sweep: zeros, ones, walking one
        for (int i = 0; i < 18; i++) begin
            logic [15:0] v;
            v = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : (16'h0001 << (i - 2));
            run_full(v);
            park();
        end

        // Abort at each cycle of the sequence, then a complete fresh run (R9)
        for (int k = 1; k <= 8; k++) begin
            vec   = 16'hC3A0 ^ 16'(k * 16'h0111);
            rst_n = 1'b1;
            repeat (k) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            chk(run_en == 1'b0, "R9 abort parks run", run_en, 0);
            chk(pc == 16'h0000, "R9 abort clears pc", pc, 0);
            chk(pc_load == 1'b0, "R9 abort no load", pc_load, 0);
            run_full(16'h2B00 + 16'(k * 16'h0013));
            park();
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule